// File: doc/BRIEF.md
# JTAG Debug Port Scan Chains

This block is the target-side scan logic of a JTAG debug port. A standard IEEE 1149.1 TAP controller, clocked by the test clock and steered by the mode-select input, moves between instruction and data scans. A 4-bit instruction register chooses one of five data chains: a 1-bit bypass, a 32-bit identification word, two 35-bit access chains (one for the debug port, one for the access port) and a 35-bit abort chain.

The access chains connect the serial interface to a simple parallel request port. When an access scan updates, the shifted-in word is issued as a one-cycle request carrying write data, a 2-bit register address, a read/write flag and a port select. When an access scan captures, it loads the most recent read data together with a 3-bit acknowledge code. A busy response makes the acknowledge report WAIT and causes the next update to be dropped. The abort chain produces an abort strobe and a flag for reserved bits that are set.

Top module: `jtag_dp_tap`

## Requirements
- R1: The TAP controller follows the IEEE 1149.1 state graph on rising edges of tck_i. Five consecutive cycles with tms_i high reach Test-Logic-Reset from any state, and rst_ni low forces that state asynchronously.
- R2: In Test-Logic-Reset the instruction register is loaded with 1110 (IDCODE). Capture-IR loads the instruction shift register with 0001, which shifts out LSB first.
- R3: Instruction decode and chain length: 1111 gives BYPASS (1 bit), 1110 gives IDCODE (32 bits), 1010 gives DPACC (35 bits), 1011 gives APACC (35 bits), 1000 gives ABORT (35 bits). Every other opcode behaves as the 1-bit BYPASS.
- R4: Capture-DR loads 0x3BA00477 for IDCODE and all zeros for BYPASS and ABORT.
- R5: TDI is sampled on rising edges of tck_i and every chain shifts LSB first. tdo_o changes only on falling edges. tdo_en_o is high from the falling edge in Shift-IR or Shift-DR until the falling edge after the shift state is left, and is low out of reset.
- R6: Capture-DR for DPACC or APACC loads rsp_rdata_i into bits 34:3 and an acknowledge into bits 2:0. The acknowledge is 001 (WAIT) when rsp_busy_i is high at capture and 010 (OK) otherwise.
- R7: When an Update-DR of DPACC or APACC is accepted, req_valid_o is high for exactly the one tck_i cycle after the rising edge that leaves Update-DR. In that cycle req_wdata_o carries shifted bits 34:3, req_addr_o bits 2:1 and req_rnw_o bit 0 (1 = read), and req_ap_o is 1 for APACC and 0 for DPACC.
- R8: When rsp_busy_i is high at the Update-DR edge, no request is issued.
- R9: A DPACC write (bit 0 = 0) to address 00 issues no request. A DPACC read of address 00 and any APACC access to address 00 are issued normally.
- R10: An ABORT Update-DR pulses abort_o for one cycle if shifted bit 0 is 1. It sets abort_rsvd_o to the OR of bits 31:1 and ignores bits 34:32. abort_rsvd_o holds that value until the next ABORT update or Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low TAP reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, falling-edge timed |
| tdo_en_o | output | 1 | High while a shift state drives tdo_o |
| rsp_busy_i | input | 1 | Response side cannot accept a request |
| rsp_rdata_i | input | DATA_W | Latest read data for capture |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_ap_o | output | 1 | 1 = access port, 0 = debug port |
| req_addr_o | output | 2 | Register address A[3:2] |
| req_rnw_o | output | 1 | 1 = read, 0 = write |
| req_wdata_o | output | DATA_W | Write data |
| abort_o | output | 1 | One-cycle abort strobe |
| abort_rsvd_o | output | 1 | Reserved abort bits were nonzero |

## Verification
Bit k of a scan appears on tdo_o after the k-th falling edge in the shift state, so the bench drives tms_i and tdi_i and reads tdo_o 1 ns after each falling edge. The request and abort strobes rise on the rising edge that leaves Update-DR and fall one cycle later. The bench therefore reads them 2 ns after the next falling edge, then again one cycle later to confirm the strobe has ended. A sweep over all sixteen opcodes works out each chain length from the delay between data shifted in and data shifted out, and checks it against the decode rule.

// File: rtl/jtag_dp_pkg.sv
package jtag_dp_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    SEL_BYPASS, SEL_IDCODE, SEL_DPACC, SEL_APACC, SEL_ABORT
  } dr_sel_e;

  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b1110;
  localparam logic [IR_W-1:0] OP_DPACC  = 4'b1010;
  localparam logic [IR_W-1:0] OP_APACC  = 4'b1011;
  localparam logic [IR_W-1:0] OP_ABORT  = 4'b1000;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE: return SEL_IDCODE;
      OP_DPACC:  return SEL_DPACC;
      OP_APACC:  return SEL_APACC;
      OP_ABORT:  return SEL_ABORT;
      default:   return SEL_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/jtag_dp_tap_fsm.sv
module jtag_dp_tap_fsm
  import jtag_dp_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TLR:    state_d = tms_i ? TLR    : RTI;
      RTI:    state_d = tms_i ? SEL_DR : RTI;
      SEL_DR: state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR: state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR: state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR: state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR: state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR: state_d = tms_i ? SEL_DR : RTI;
      SEL_IR: state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR: state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR: state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR: state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR: state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR: state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/jtag_dp_ir.sv
module jtag_dp_ir
  import jtag_dp_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  output logic [IR_W-1:0] ir_o,
  output logic            lsb_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      ir_q <= OP_IDCODE;
    end else begin
      case (state_i)
        TLR:    ir_q <= OP_IDCODE;
        CAP_IR: sr_q <= IR_CAPTURE;
        SH_IR:  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        UPD_IR: ir_q <= sr_q;
        default: ;
      endcase
    end
  end

  assign ir_o  = ir_q;
  assign lsb_o = sr_q[0];
endmodule

// File: rtl/jtag_dp_dr.sv
module jtag_dp_dr
  import jtag_dp_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] IDCODE_VAL = 32'h3BA00477
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  tap_state_e        state_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              rsp_busy_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              req_valid_o,
  output logic              req_ap_o,
  output logic [1:0]        req_addr_o,
  output logic              req_rnw_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic              abort_o,
  output logic              abort_rsvd_o,
  output logic              lsb_o
);
  localparam int SR_W = DATA_W + 3;
  localparam int ID_W = 32;

  dr_sel_e           sel;
  logic [SR_W-1:0]   sr_q, sr_d;
  logic              upd, acc_sel, dp_rsvd_wr, issue;
  logic              valid_q, ap_q, rnw_q, abort_q, rsvd_q;
  logic [1:0]        addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign sel = decode_op(ir_i);

  always_comb begin
    sr_d = sr_q;
    case (state_i)
      CAP_DR: begin
        case (sel)
          SEL_IDCODE:           sr_d = SR_W'(IDCODE_VAL);
          SEL_DPACC, SEL_APACC: sr_d = {rsp_rdata_i, rsp_busy_i ? ACK_WAIT : ACK_OK};
          default:              sr_d = '0;
        endcase
      end
      SH_DR: begin
        sr_d = sr_q >> 1;
        case (sel)
          SEL_BYPASS: sr_d[0]      = tdi_i;
          SEL_IDCODE: sr_d[ID_W-1] = tdi_i;
          default:    sr_d[SR_W-1] = tdi_i;
        endcase
      end
      default: ;
    endcase
  end

  assign upd        = (state_i == UPD_DR);
  assign acc_sel    = (sel == SEL_DPACC) || (sel == SEL_APACC);
  assign dp_rsvd_wr = (sel == SEL_DPACC) && (sr_q[2:1] == 2'b00) && !sr_q[0];
  assign issue      = upd && acc_sel && !rsp_busy_i && !dp_rsvd_wr;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      valid_q <= 1'b0;
      ap_q    <= 1'b0;
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      abort_q <= 1'b0;
      rsvd_q  <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      valid_q <= issue;
      if (issue) begin
        wdata_q <= sr_q[SR_W-1:3];
        addr_q  <= sr_q[2:1];
        rnw_q   <= sr_q[0];
        ap_q    <= (sel == SEL_APACC);
      end
      abort_q <= upd && (sel == SEL_ABORT) && sr_q[0];
      if (state_i == TLR)                 rsvd_q <= 1'b0;
      else if (upd && sel == SEL_ABORT)   rsvd_q <= |sr_q[ID_W-1:1];
    end
  end

  assign req_valid_o  = valid_q;
  assign req_ap_o     = ap_q;
  assign req_addr_o   = addr_q;
  assign req_rnw_o    = rnw_q;
  assign req_wdata_o  = wdata_q;
  assign abort_o      = abort_q;
  assign abort_rsvd_o = rsvd_q;
  assign lsb_o        = sr_q[0];
endmodule

// File: rtl/jtag_dp_tap.sv
module jtag_dp_tap
  import jtag_dp_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] IDCODE_VAL = 32'h3BA00477
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  input  logic              rsp_busy_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              req_valid_o,
  output logic              req_ap_o,
  output logic [1:0]        req_addr_o,
  output logic              req_rnw_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic              abort_o,
  output logic              abort_rsvd_o
);
  tap_state_e      state_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb, tdo_q, tdo_en_q;

  jtag_dp_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state_q)
  );

  jtag_dp_ir u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tdi_i   (tdi_i),
    .state_i (state_q),
    .ir_o    (ir_q),
    .lsb_o   (ir_lsb)
  );

  jtag_dp_dr #(.DATA_W(DATA_W), .IDCODE_VAL(IDCODE_VAL)) u_dr (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .tdi_i        (tdi_i),
    .state_i      (state_q),
    .ir_i         (ir_q),
    .rsp_busy_i   (rsp_busy_i),
    .rsp_rdata_i  (rsp_rdata_i),
    .req_valid_o  (req_valid_o),
    .req_ap_o     (req_ap_o),
    .req_addr_o   (req_addr_o),
    .req_rnw_o    (req_rnw_o),
    .req_wdata_o  (req_wdata_o),
    .abort_o      (abort_o),
    .abort_rsvd_o (abort_rsvd_o),
    .lsb_o        (dr_lsb)
  );

  // Output stage retimed to the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else if (state_q == SH_DR) begin
      tdo_q    <= dr_lsb;
      tdo_en_q <= 1'b1;
    end else if (state_q == SH_IR) begin
      tdo_q    <= ir_lsb;
      tdo_en_q <= 1'b1;
    end else begin
      tdo_en_q <= 1'b0;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = tdo_en_q;
endmodule

// File: rtl/jtag_dp_tap_chk.sv
module jtag_dp_tap_chk
  import jtag_dp_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir,
  input logic            rsp_busy_i,
  input logic            req_valid_o,
  input logic            abort_o,
  input logic            tdo_en_o
);
  assert_tms_reset_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ($past(tms_i, 4) && $past(tms_i, 3) && $past(tms_i, 2) && $past(tms_i, 1) && tms_i)
      |=> (state == TLR));

  assert_tlr_ir_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == TLR) |=> (ir == OP_IDCODE));

  assert_tdo_en_shift_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> (state == SH_DR || state == SH_IR));

  assert_req_single_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);

  assert_busy_drop_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == UPD_DR && (ir == OP_DPACC || ir == OP_APACC) && rsp_busy_i)
      |=> !req_valid_o);

  assert_abort_single_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

bind jtag_dp_tap jtag_dp_tap_chk u_chk (
  .tck_i       (tck_i),
  .rst_ni      (rst_ni),
  .tms_i       (tms_i),
  .state       (state_q),
  .ir          (ir_q),
  .rsp_busy_i  (rsp_busy_i),
  .req_valid_o (req_valid_o),
  .abort_o     (abort_o),
  .tdo_en_o    (tdo_en_o)
);

// File: tb/jtag_dp_tap_tb_top.sv
module jtag_dp_tap_tb_top;
  localparam int TCK_PERIOD = 20;
  localparam int DATA_W     = 32;
  localparam logic [31:0] ID_EXP = 32'h3BA00477;

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0, busy = 1'b0;
  logic [DATA_W-1:0] rdata = '0;
  logic tdo, tdo_en, req_valid, req_ap, req_rnw, abort_p, abort_rsvd;
  logic [1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic smp_tdo, smp_en;
  int n_checks = 0, n_fail = 0;

  jtag_dp_tap #(.DATA_W(DATA_W)) dut_i (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_en_o(tdo_en), .rsp_busy_i(busy), .rsp_rdata_i(rdata),
    .req_valid_o(req_valid), .req_ap_o(req_ap), .req_addr_o(req_addr),
    .req_rnw_o(req_rnw), .req_wdata_o(req_wdata),
    .abort_o(abort_p), .abort_rsvd_o(abort_rsvd)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  initial begin
    repeat (50000) @(posedge tck);
    n_checks++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    smp_tdo = tdo; smp_en = tdo_en;
  endtask

  task automatic settle();
    @(negedge tck); #2;
  endtask

  task automatic tms_reset();
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap = '0;
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i]);
      cap[i] = smp_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n,
                         output logic [63:0] dout, output logic en_all);
    step(1, 0); step(0, 0); step(0, 0);
    dout = '0; en_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = smp_tdo;
      en_all &= smp_en;
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic int chain_len(input logic [3:0] op);
    case (op)
      4'b1110: return 32;
      4'b1010, 4'b1011, 4'b1000: return 35;
      default: return 1;
    endcase
  endfunction

  initial begin
    logic [3:0]  cap;
    logic [63:0] dout, exp, capv, din;
    logic        en;
    int          len;

    repeat (3) @(negedge tck);
    #2;
    check("R5 reset tdo_en", {63'b0, tdo_en}, 64'd0);
    check("R7 reset req_valid", {63'b0, req_valid}, 64'd0);
    check("R10 reset abort", {62'b0, abort_p, abort_rsvd}, 64'd0);
    rst_n = 1'b1;
    step(0, 0);

    scan_dr(64'd0, 32, dout, en);
    check("R1 R2 R4 idcode after reset", dout, {32'b0, ID_EXP});
    check("R5 tdo_en during shift", {63'b0, en}, 64'd1);
    settle();
    check("R5 tdo_en idle", {63'b0, tdo_en}, 64'd0);

    scan_ir(4'b1111, cap);
    check("R2 ir capture", {60'b0, cap}, 64'd1);

    // Opcode sweep: chain length seen as delay between TDI and TDO (R3)
    busy  = 1'b1;
    rdata = 32'hC0DE1234;
    din   = 64'h00000095C3E71B6A;
    for (int op = 0; op < 16; op++) begin
      scan_ir(op[3:0], cap);
      scan_dr(din, 40, dout, en);
      len = chain_len(op[3:0]);
      if (op == 4'b1110)                   capv = {32'b0, ID_EXP};
      else if (op == 4'b1010 || op == 4'b1011) capv = {29'b0, rdata, 3'b001};
      else                                 capv = '0;
      exp = '0;
      for (int i = 0; i < 40; i++)
        exp[i] = (i < len) ? capv[i] : din[i - len];
      check($sformatf("R3 R4 R6 opcode %b chain", op[3:0]), dout, exp);
      settle();
      if (op == 4'b1010 || op == 4'b1011)
        check("R8 busy drops request", {63'b0, req_valid}, 64'd0);
    end

    busy  = 1'b0;
    rdata = 32'h13579BDF;

    scan_ir(4'b1010, cap);
    scan_dr({29'b0, 32'hDEADBEEF, 2'b01, 1'b0}, 35, dout, en);
    check("R6 capture ok ack", dout, {29'b0, 32'h13579BDF, 3'b010});
    settle();
    check("R7 dp write fields", {req_valid, req_ap, req_addr, req_rnw, req_wdata},
          {1'b1, 1'b0, 2'b01, 1'b0, 32'hDEADBEEF});
    settle();
    check("R7 request one cycle", {63'b0, req_valid}, 64'd0);

    scan_ir(4'b1011, cap);
    scan_dr({29'b0, 32'h0000A5A5, 2'b11, 1'b1}, 35, dout, en);
    settle();
    check("R7 ap read fields", {req_valid, req_ap, req_addr, req_rnw, req_wdata},
          {1'b1, 1'b1, 2'b11, 1'b1, 32'h0000A5A5});

    scan_ir(4'b1010, cap);
    scan_dr({29'b0, 32'h11112222, 2'b00, 1'b0}, 35, dout, en);
    settle();
    check("R9 dp write addr 00 dropped", {63'b0, req_valid}, 64'd0);
    scan_dr({29'b0, 32'h0, 2'b00, 1'b1}, 35, dout, en);
    settle();
    check("R9 dp read addr 00 issued", {req_valid, req_ap, req_addr, req_rnw},
          {1'b1, 1'b0, 2'b00, 1'b1});
    scan_ir(4'b1011, cap);
    scan_dr({29'b0, 32'h33334444, 2'b00, 1'b0}, 35, dout, en);
    settle();
    check("R9 ap write addr 00 issued", {req_valid, req_ap, req_addr, req_rnw, req_wdata},
          {1'b1, 1'b1, 2'b00, 1'b0, 32'h33334444});

    busy = 1'b1;
    scan_dr({29'b0, 32'h55556666, 2'b10, 1'b0}, 35, dout, en);
    check("R6 capture wait ack", dout, {29'b0, 32'h13579BDF, 3'b001});
    settle();
    check("R8 busy write dropped", {63'b0, req_valid}, 64'd0);
    busy = 1'b0;

    scan_ir(4'b1000, cap);
    scan_dr(64'h1, 35, dout, en);
    settle();
    check("R10 abort pulse", {62'b0, abort_p, abort_rsvd}, 64'b10);
    settle();
    check("R10 abort one cycle", {63'b0, abort_p}, 64'd0);
    scan_dr(64'h20, 35, dout, en);
    settle();
    check("R10 reserved bit set", {62'b0, abort_p, abort_rsvd}, 64'b01);
    scan_dr(64'h700000001, 35, dout, en);
    settle();
    check("R10 bits 34:32 ignored", {62'b0, abort_p, abort_rsvd}, 64'b10);
    scan_dr(64'h80000000, 35, dout, en);
    settle();
    check("R10 bit 31 reserved", {63'b0, abort_rsvd}, 64'd1);

    tms_reset();
    settle();
    check("R1 R10 tms reset clears flag", {63'b0, abort_rsvd}, 64'd0);
    scan_dr(64'd0, 32, dout, en);
    check("R1 R2 idcode after tms reset", dout, {32'b0, ID_EXP});

    scan_ir(4'b1111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    rst_n = 1'b0;
    #3;
    rst_n = 1'b1;
    step(0, 0);
    scan_dr(64'd0, 32, dout, en);
    check("R1 async reset restores idcode", dout, {32'b0, ID_EXP});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule